// File: doc/BRIEF.md
# Shadow-Buffered Multi-Channel PWM Controller

This block drives several independent pulse-width outputs from one register bus. Each channel has a period and an active-time register, both in clock cycles. Software writes these into shadow copies. The running counter uses live copies, which change only when software produces a rising edge on the channel's commit bit. Because the commit edge moves both values in the same clock, a waveform never mixes a new period with an old active time. Each commit restarts the period from count zero.

A channel starts on a rising edge of its run bit. Clearing that bit does not stop the channel, so software parks an output by committing an active time of zero. The output level sense is chosen by a polarity bit. That bit can be changed until the channel first runs and is frozen from then on. A soft-reset bit clears the counter, the live copies and the running flag, and leaves the shadow copies as they are.

Each channel has a 0x20-byte window at byte offset 32·n. Inside the window, the control word is at +0x00 and the spare word at +0x04, which reads as zero and ignores writes. The shadow period is at +0x08, the shadow active time at +0x0C and the status word at +0x10. A bus transfer takes effect in the cycle where `psel` and `penable` are both high.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset, every control word reads 0x120 (polarity bit 8 = 1, mode field bits 5:4 = 2). Shadow period, shadow active time and status read 0, and every output is low.
- R2: A write that takes control bit 0 from 0 to 1 starts the channel with the count at 0. On the k-th clock after that write, the count is k mod P, and the output is active while the count is below the live active time A.
- R3: Writing control bit 0 from 1 to 0 has no effect on a running channel. The waveform continues unchanged and status bit 0 stays 1.
- R4: Writes to the shadow period and active time leave the live waveform untouched. A write that takes control bit 2 from 0 to 1 copies both shadow values into the live copies in the same clock and restarts the count at 0.
- R5: Writing control bit 2 as 1 while it already reads 1 commits nothing.
- R6: With a live active time of 0, the output stays at its inactive level for the whole period.
- R7: A live active time equal to or above the live period gives a constant active level.
- R8: Control bit 8 = 1 makes the output high while active, and 0 inverts it. The bit is writable only while the channel has never run since reset or soft reset. Later writes to it are ignored.
- R9: Writing control bit 1 as 1 clears the count, the live period, the live active time, the running flag and control bit 0. The shadow registers keep their values. After a new start, the output stays inactive until the next commit.
- R10: Channels are independent. Activity on one channel changes no other channel's output.
- R11: Status bit 0 reads the running flag and status bit 1 reads the present output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address (channel = upper bits, register = low 5 bits) |
| pwdata | input | W | Write data |
| prdata | output | W | Read data, valid during the access phase |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench goes after the edge rules:
- It clears the run bit on a live channel. A design that treats the run bit as a level would stop the output.
- It rewrites a commit bit that is already set. A design that triggers on the level would reload the live values and restart the period early, which breaks the predicted phase.
- It loads the shadow registers mid-waveform. A design without real shadowing would change the waveform at once.
- It attempts a polarity flip after start. A design without the lock would invert a running output.

It also checks the zero and saturated active times, the soft reset that must keep the shadows, and a second inverted channel running beside the first.

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int NUM_CH = 6,
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [W-1:0]      pwdata,
  output logic [W-1:0]      prdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int WIN_LSB = 5;
  localparam int CH_W    = ADDR_W - WIN_LSB;
  localparam logic [9:0] RST_CTL = 10'h120;

  logic [9:0]   ctl_q      [NUM_CH];
  logic [W-1:0] sh_per_q   [NUM_CH];
  logic [W-1:0] sh_act_q   [NUM_CH];
  logic [W-1:0] live_per_q [NUM_CH];
  logic [W-1:0] live_act_q [NUM_CH];
  logic [W-1:0] cnt_q      [NUM_CH];
  logic [NUM_CH-1:0] started_q;

  logic [NUM_CH-1:0] wctl, wper, wact, st_e, up_e, srst, act;
  logic [CH_W-1:0]   rch;
  logic [WIN_LSB-1:0] off;
  logic bus_wr;

  assign rch    = paddr[ADDR_W-1:WIN_LSB];
  assign off    = paddr[WIN_LSB-1:0];
  assign bus_wr = psel && penable && pwrite;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wctl[i] = bus_wr && (rch == CH_W'(i)) && (off == 5'h00);
      wper[i] = bus_wr && (rch == CH_W'(i)) && (off == 5'h08);
      wact[i] = bus_wr && (rch == CH_W'(i)) && (off == 5'h0C);
      st_e[i] = wctl[i] && pwdata[0] && !ctl_q[i][0];
      up_e[i] = wctl[i] && pwdata[2] && !ctl_q[i][2];
      srst[i] = wctl[i] && pwdata[1];
      act[i]  = started_q[i] && (cnt_q[i] < live_act_q[i]);
      pwm_out[i] = ctl_q[i][8] ? act[i] : !act[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        ctl_q[i]      <= RST_CTL;
        sh_per_q[i]   <= '0;
        sh_act_q[i]   <= '0;
        live_per_q[i] <= '0;
        live_act_q[i] <= '0;
        cnt_q[i]      <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wctl[i])
          ctl_q[i] <= {pwdata[9], started_q[i] ? ctl_q[i][8] : pwdata[8],
                       pwdata[7:2], 1'b0, pwdata[0] && !pwdata[1]};
        if (wper[i]) sh_per_q[i] <= pwdata;
        if (wact[i]) sh_act_q[i] <= pwdata;
        if (srst[i]) begin
          started_q[i]  <= 1'b0;
          cnt_q[i]      <= '0;
          live_per_q[i] <= '0;
          live_act_q[i] <= '0;
        end else begin
          if (up_e[i]) begin
            live_per_q[i] <= sh_per_q[i];
            live_act_q[i] <= sh_act_q[i];
          end
          if (st_e[i]) started_q[i] <= 1'b1;
          if (up_e[i] || st_e[i])
            cnt_q[i] <= '0;
          else if (started_q[i])
            cnt_q[i] <= (live_per_q[i] == '0 || cnt_q[i] >= live_per_q[i] - 1'b1)
                        ? '0 : cnt_q[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    prdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (psel && !pwrite && rch == CH_W'(i))
        case (off)
          5'h00:   prdata = {{(W-10){1'b0}}, ctl_q[i]};
          5'h08:   prdata = sh_per_q[i];
          5'h0C:   prdata = sh_act_q[i];
          5'h10:   prdata = {{(W-2){1'b0}}, pwm_out[i], started_q[i]};
          default: prdata = '0;
        endcase
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_start_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q[g] && !srst[g]) |=> started_q[g]);
    assert_pol_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      started_q[g] |=> $stable(ctl_q[g][8]));
    assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_e[g] && !srst[g]) |=> ($stable(live_per_q[g]) && $stable(live_act_q[g])));
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q[g] && live_per_q[g] != '0) |-> (cnt_q[g] < live_per_q[g]));
    assert_zero_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_act_q[g] == '0) |-> (pwm_out[g] != ctl_q[g][8]));
  end
endmodule

// File: tb/pwm_shadow_bank_tb_top.sv
module pwm_shadow_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 6;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [NUM_CH-1:0] pwm_out;

  pwm_shadow_bank dut_i (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int cyc; int ch; bit exp; string req; } item_t;
  item_t sb_q[$];
  int cyc = 0, tests = 0, fails = 0, rd_cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    for (int k = 0; k < sb_q.size(); ) begin
      if (sb_q[k].cyc <= cyc) begin
        check(sb_q[k].cyc == cyc && pwm_out[sb_q[k].ch] == sb_q[k].exp,
              sb_q[k].req, pwm_out[sb_q[k].ch], sb_q[k].exp);
        sb_q.delete(k);
      end else k++;
    end
  end

  function automatic bit lvl(int t0, int p, int a, bit pol, int c);
    bit on;
    on = (p == 0) ? (a > 0) : (((c - t0) % p) < a);
    return pol ? on : !on;
  endfunction

  task automatic wr(int ch, int off, int data);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0;
    paddr = 8'(ch * 32 + off); pwdata = data;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(int ch, int off, output int data);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = 8'(ch * 32 + off);
    @(negedge clk); penable = 1; #1; data = prdata; rd_cyc = cyc;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic push_const(int ch, bit v, int n, string req);
    for (int k = 1; k <= n; k++) sb_q.push_back('{cyc + k, ch, v, req});
  endtask

  task automatic run(int ch, int t0, int p, int a, bit pol, int n, string req);
    for (int k = 1; k <= n; k++)
      sb_q.push_back('{cyc + k, ch, lvl(t0, p, a, pol, cyc + k), req});
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int d, t0, t1, t4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 'h00, d); check(d == 'h120, "R1 ctl", d, 'h120);
    rd(0, 'h08, d); check(d == 0, "R1 per", d, 0);
    rd(0, 'h0C, d); check(d == 0, "R1 act", d, 0);
    rd(0, 'h10, d); check(d == 0, "R1 status", d, 0);
    check(pwm_out == '0, "R1 outputs", pwm_out, 0);
    // R2 configure, commit, stay idle until started
    wr(0, 'h08, 10); wr(0, 'h0C, 3); wr(0, 'h00, 'h124);
    run(0, 0, 1, 0, 1, 5, "R2 idle before start");
    wr(0, 'h00, 'h125); t0 = cyc;
    push_const(1, 0, 25, "R10 idle neighbour");
    run(0, t0, 10, 3, 1, 25, "R2 waveform");
    // R3 clearing run bit does not stop
    wr(0, 'h00, 'h124);
    run(0, t0, 10, 3, 1, 15, "R3 keeps running");
    rd(0, 'h10, d); check(d[0] == 1, "R3/R11 running flag", d[0], 1);
    check(d[1] == lvl(t0, 10, 3, 1, rd_cyc), "R11 level", d[1], lvl(t0, 10, 3, 1, rd_cyc));
    // R4 shadow then commit
    wr(0, 'h08, 6); wr(0, 'h0C, 2);
    run(0, t0, 10, 3, 1, 12, "R4 shadow not live");
    rd(0, 'h08, d); check(d == 6, "R4 shadow readback", d, 6);
    wr(0, 'h00, 'h120);
    run(0, t0, 10, 3, 1, 6, "R4 clear commit bit");
    wr(0, 'h00, 'h124); t1 = cyc;
    run(0, t1, 6, 2, 1, 18, "R4 committed");
    // R5 level-high commit does nothing
    wr(0, 'h0C, 5); wr(0, 'h00, 'h124);
    run(0, t1, 6, 2, 1, 12, "R5 no recommit");
    wr(0, 'h00, 'h120); wr(0, 'h00, 'h124); t1 = cyc;
    run(0, t1, 6, 5, 1, 12, "R5 commit after clear");
    // R6 zero active time
    wr(0, 'h0C, 0); wr(0, 'h00, 'h120); wr(0, 'h00, 'h124); t1 = cyc;
    run(0, t1, 6, 0, 1, 14, "R6 zero active");
    // R7 active at/above period
    wr(0, 'h0C, 9); wr(0, 'h00, 'h120); wr(0, 'h00, 'h124); t1 = cyc;
    run(0, t1, 6, 9, 1, 14, "R7 saturated");
    // R8 polarity locked on running channel, free on idle channel
    wr(0, 'h00, 'h024);
    rd(0, 'h00, d); check(d == 'h124, "R8 pol locked", d, 'h124);
    check(pwm_out[0] == 1, "R8 output not inverted", pwm_out[0], 1);
    wr(1, 'h00, 'h020);
    rd(1, 'h00, d); check(d == 'h020, "R8 pol writable", d, 'h020);
    check(pwm_out[1] == 1, "R8 idle inverted level", pwm_out[1], 1);
    wr(1, 'h08, 4); wr(1, 'h0C, 1); wr(1, 'h00, 'h024); wr(1, 'h00, 'h025); t4 = cyc;
    push_const(0, 1, 12, "R10 ch0 unaffected");
    run(1, t4, 4, 1, 0, 12, "R8 inverted waveform");
    rd(1, 'h10, d);
    check(d[1:0] == {lvl(t4, 4, 1, 0, rd_cyc), 1'b1}, "R11 status ch1", d[1:0],
          {lvl(t4, 4, 1, 0, rd_cyc), 1'b1});
    // R9 soft reset
    wr(0, 'h00, 'h122);
    rd(0, 'h10, d); check(d == 0, "R9 status cleared", d, 0);
    rd(0, 'h08, d); check(d == 6, "R9 shadow per kept", d, 6);
    rd(0, 'h0C, d); check(d == 9, "R9 shadow act kept", d, 9);
    rd(0, 'h00, d); check(d == 'h120, "R9 ctl", d, 'h120);
    wr(0, 'h00, 'h121);
    run(0, 0, 1, 0, 1, 8, "R9 live cleared");
    rd(0, 'h10, d); check(d == 1, "R9 restarted inactive", d, 1);
    run(1, t4, 4, 1, 0, 8, "R10 ch1 unaffected");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule